// File: doc/BRIEF.md
# Receive Event Status Register Unit

This unit keeps the four receive-path event flags of a packet radio receiver: an uncorrectable header error, a completed frame, a frame whose check sequence matched, and a frame whose check sequence did not match. It takes single-cycle pulses from the receive datapath. These are a double-bit header error, a corrected single-bit header error, the end of a frame with its CRC verdict, and the completion or failure of the timestamp adjustment. The flags are held in a status word that the host can read and clear.

A frame-end result is not shown at once. The CRC verdict is held inside the unit until the timestamp adjustment reports done or error. Only then do the frame-ready flag and one CRC flag appear, in the same cycle, so that software never sees a finished frame with a stale timestamp. The host can clear any flag by writing a 1 to its bit. Every receiver enable also clears the flags, whether it comes from the host or from the unit's own automatic re-arm.

On a header error the unit can abort the reception and can then re-enable the receiver, depending on two configuration bits. Two gated, saturating counters record header errors and CRC failures. An interrupt line is high while any flag is set whose mask bit is also set.

Top module: `rx_evt_status`

## Requirements
- R1: After reset the status word, configuration word, mask word and both counters read 0, and `irq_o`, `rx_abort_o` and `rx_en_o` are 0.
- R2: A `hdr_dbl_err_i` pulse sets the header-error flag at status bit 12 on the next clock edge. A `hdr_sgl_err_i` pulse leaves the status word unchanged.
- R3: `frm_end_i` alone changes no flag. At the first `ts_done_i` or `ts_err_i` pulse after it, frame-ready (bit 13) sets together with CRC-good (bit 14) if `crc_ok_i` was 1 at frame end, or with CRC-error (bit 15) if it was 0.
- R4: A `ts_done_i` or `ts_err_i` pulse that has no pending frame end changes no flag.
- R5: A write to address 0 clears each status flag whose bit is 1 in the write data. Zero bits leave their flag unchanged. A set event on the same bit in the same cycle wins over the clear.
- R6: Any cycle with `rx_en_o` high clears all four flags and discards a pending frame-end result. `rx_en_o` is high while `host_rx_en_i` is high or for one cycle of automatic re-enable.
- R7: A header error raises `rx_abort_o` for one cycle on the next edge, unless configuration bit 0 (address 1) is set. When an abort occurs and configuration bit 1 is set, `rx_en_o` goes high for one cycle in the cycle after the abort pulse.
- R8: The header-error counter (address 3) and the CRC-error counter (address 4) each add one per event only while configuration bit 2 is 1. Each saturates at 4095.
- R9: Writing configuration bit 2 from 0 to 1 clears both counters. Writing it while it is already 1 does not.
- R10: `irq_o` is high while any status flag is set whose bit at the same position in the mask word (address 2, bits 12 to 15) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_dbl_err_i | input | 1 | Uncorrectable header error pulse |
| hdr_sgl_err_i | input | 1 | Corrected single-bit header error pulse |
| frm_end_i | input | 1 | Frame end pulse |
| crc_ok_i | input | 1 | CRC verdict, valid with frame end |
| ts_done_i | input | 1 | Timestamp adjustment done pulse |
| ts_err_i | input | 1 | Timestamp adjustment error pulse |
| host_rx_en_i | input | 1 | Receiver enable from the host |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| rx_abort_o | output | 1 | Reception abort pulse |
| rx_en_o | output | 1 | Effective receiver enable |
| irq_o | output | 1 | Interrupt request |

## Verification
A lost or stuck pending frame-end latch shows up at the next timestamp pulse. Frame-ready and a CRC flag then appear when they should not, or stay absent, and this is visible in the status word one edge after the pulse. A wrong set-versus-clear priority, or a clear path that fails to reach every flag, shows in the status word read right after the write or the receiver enable. A counter that wraps instead of holding, or that misses its clear on enable, is visible in its read register at the first event after the boundary.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;
   localparam int BIT_HDR  = 12;
   localparam int BIT_RDY  = 13;
   localparam int BIT_GOOD = 14;
   localparam int BIT_BAD  = 15;
   localparam int NFLAG    = 4;

   localparam logic [2:0] A_STATUS = 3'd0;
   localparam logic [2:0] A_CONFIG = 3'd1;
   localparam logic [2:0] A_MASK   = 3'd2;
   localparam logic [2:0] A_HDRCNT = 3'd3;
   localparam logic [2:0] A_CRCCNT = 3'd4;

   typedef struct packed {
      logic cnt_en;
      logic auto_reen;
      logic dis_abort;
   } cfg_t;
endpackage

// File: rtl/rx_evt_regs.sv
module rx_evt_regs
   import rx_evt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output cfg_t              cfg,
   output logic [NFLAG-1:0]  mask,
   output logic [NFLAG-1:0]  w1c,
   output logic              cnt_clr
);
   logic wr_cfg, wr_mask;

   assign wr_cfg  = wr_en && (wr_addr == A_CONFIG);
   assign wr_mask = wr_en && (wr_addr == A_MASK);

   assign w1c     = (wr_en && (wr_addr == A_STATUS)) ? wr_data[BIT_BAD:BIT_HDR] : '0;
   assign cnt_clr = wr_cfg && wr_data[2] && !cfg.cnt_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= '0;
         mask <= '0;
      end else begin
         if (wr_cfg)
            cfg <= cfg_t'(wr_data[2:0]);
         if (wr_mask)
            mask <= wr_data[BIT_BAD:BIT_HDR];
      end
   end
endmodule

// File: rtl/rx_evt_flags.sv
module rx_evt_flags
   import rx_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_set,
   input  logic             frm_end,
   input  logic             crc_ok,
   input  logic             ts_any,
   input  logic [NFLAG-1:0] w1c,
   input  logic             rx_en,
   output logic [NFLAG-1:0] flags,
   output logic             bad_evt
);
   logic             pend_v, pend_ok;
   logic             release_now, rel_ok;
   logic [NFLAG-1:0] set_v, clr_v;

   assign release_now = ts_any && (pend_v || frm_end);
   assign rel_ok      = frm_end ? crc_ok : pend_ok;
   assign bad_evt     = release_now && !rel_ok;

   // index 0 hdr, 1 ready, 2 good, 3 bad (status bits 12..15)
   assign set_v = {release_now && !rel_ok, release_now && rel_ok, release_now, hdr_set};
   assign clr_v = w1c | {NFLAG{rx_en}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v  <= 1'b0;
         pend_ok <= 1'b0;
      end else if (release_now) begin
         pend_v  <= 1'b0;
      end else if (frm_end) begin
         pend_v  <= 1'b1;
         pend_ok <= crc_ok;
      end else if (rx_en) begin
         pend_v  <= 1'b0;
      end
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set_v[i])
            flags[i] <= 1'b1;
         else if (clr_v[i])
            flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_evt_ctl.sv
module rx_evt_ctl
   import rx_evt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hdr_set,
   input  cfg_t cfg,
   input  logic host_rx_en,
   output logic abort,
   output logic rx_en
);
   logic reen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort  <= 1'b0;
         reen_q <= 1'b0;
      end else begin
         abort  <= hdr_set && !cfg.dis_abort;
         reen_q <= abort && cfg.auto_reen;
      end
   end

   assign rx_en = host_rx_en || reen_q;
endmodule

// File: rtl/rx_evt_ctr.sv
module rx_evt_ctr #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (en && inc && (cnt != MAXV))
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rx_evt_status.sv
module rx_evt_status
   import rx_evt_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 12,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_dbl_err_i,
   input  logic              hdr_sgl_err_i,
   input  logic              frm_end_i,
   input  logic              crc_ok_i,
   input  logic              ts_done_i,
   input  logic              ts_err_i,
   input  logic              host_rx_en_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [2:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rx_abort_o,
   output logic              rx_en_o,
   output logic              irq_o
);
   localparam int NCTR = 2;

   if (DATA_W < 16) begin : g_bad_dw
      $error("DATA_W must hold status bit 15");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cw
      $error("CNT_W must be between 1 and DATA_W");
   end

   cfg_t             cfg_q;
   logic [NFLAG-1:0] mask_q, w1c, flags_q;
   logic             cnt_clr, bad_evt, irq_raw;
   logic [NCTR-1:0]  ctr_inc;
   logic [CNT_W-1:0] ctr_val [NCTR];

   // single-bit header errors are corrected upstream and raise nothing
   logic unused_sgl;
   assign unused_sgl = hdr_sgl_err_i;

   rx_evt_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .cfg(cfg_q), .mask(mask_q), .w1c(w1c), .cnt_clr(cnt_clr)
   );

   rx_evt_flags u_flags (
      .clk(clk), .rst_n(rst_n), .hdr_set(hdr_dbl_err_i), .frm_end(frm_end_i),
      .crc_ok(crc_ok_i), .ts_any(ts_done_i || ts_err_i), .w1c(w1c),
      .rx_en(rx_en_o), .flags(flags_q), .bad_evt(bad_evt)
   );

   rx_evt_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .hdr_set(hdr_dbl_err_i), .cfg(cfg_q),
      .host_rx_en(host_rx_en_i), .abort(rx_abort_o), .rx_en(rx_en_o)
   );

   assign ctr_inc = {bad_evt, hdr_dbl_err_i};

   for (genvar c = 0; c < NCTR; c++) begin : g_ctr
      rx_evt_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cfg_q.cnt_en),
         .inc(ctr_inc[c]), .cnt(ctr_val[c])
      );
   end

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         A_STATUS: rd_data_o[BIT_BAD:BIT_HDR] = flags_q;
         A_CONFIG: rd_data_o[2:0]             = cfg_q;
         A_MASK:   rd_data_o[BIT_BAD:BIT_HDR] = mask_q;
         A_HDRCNT: rd_data_o[CNT_W-1:0]       = ctr_val[0];
         A_CRCCNT: rd_data_o[CNT_W-1:0]       = ctr_val[1];
         default:  rd_data_o = '0;
      endcase
   end

   assign irq_raw = |(flags_q & mask_q);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end
endmodule

// File: rtl/rx_evt_chk.sv
module rx_evt_chk
   import rx_evt_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hdr_dbl_err_i,
   input logic             ts_done_i,
   input logic             ts_err_i,
   input logic             wr_en_i,
   input logic             rx_en_o,
   input logic             rx_abort_o,
   input cfg_t             cfg,
   input logic [NFLAG-1:0] flags,
   input logic [CNT_W-1:0] hdr_cnt
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   AST_HDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_dbl_err_i |=> flags[0]); // R2
   AST_RDY_AFTER_TS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> $past(ts_done_i || ts_err_i)); // R3
   AST_GOOD_WITH_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[2]) |-> flags[1]); // R3
   AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en_o && !hdr_dbl_err_i && !ts_done_i && !ts_err_i) |=> (flags == '0)); // R6
   AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_dbl_err_i && !cfg.dis_abort) |=> rx_abort_o); // R7
   AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_dbl_err_i |=> !rx_abort_o); // R7
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.cnt_en && !wr_en_i) |=> $stable(hdr_cnt)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_cnt == MAXV) |=> (hdr_cnt == MAXV || hdr_cnt == '0)); // R8
endmodule

bind rx_evt_status rx_evt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hdr_dbl_err_i(hdr_dbl_err_i), .ts_done_i(ts_done_i),
   .ts_err_i(ts_err_i), .wr_en_i(wr_en_i), .rx_en_o(rx_en_o), .rx_abort_o(rx_abort_o),
   .cfg(cfg_q), .flags(flags_q), .hdr_cnt(ctr_val[0])
);

// File: tb/sim_rx_evt_status.sv
`timescale 1ns/100ps
module sim_rx_evt_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_dbl_err_i = 0, hdr_sgl_err_i = 0, frm_end_i = 0, crc_ok_i = 0;
   logic        ts_done_i = 0, ts_err_i = 0, host_rx_en_i = 0, wr_en_i = 0;
   logic [2:0]  wr_addr_i = 0, rd_addr_i = 0;
   logic [31:0] wr_data_i = 0;
   logic [31:0] rd_data_o;
   logic        rx_abort_o, rx_en_o, irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rx_evt_status u0 (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      rd_addr_i = a;
      #0.5;
      v = rd_data_o;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic p_hdr();   @(negedge clk); hdr_dbl_err_i = 1; @(negedge clk); hdr_dbl_err_i = 0; endtask
   task automatic p_ts(bit e); @(negedge clk); if (e) ts_err_i = 1; else ts_done_i = 1;
                               @(negedge clk); ts_err_i = 0; ts_done_i = 0; endtask
   task automatic p_end(bit ok); @(negedge clk); frm_end_i = 1; crc_ok_i = ok;
                               @(negedge clk); frm_end_i = 0; crc_ok_i = 0; endtask
   task automatic p_en();    @(negedge clk); host_rx_en_i = 1; @(negedge clk); host_rx_en_i = 0; endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v); chk($sformatf("R1 reg %0d", a), v, 0);
      end
      chk("R1 irq", irq_o, 0); chk("R1 abort", rx_abort_o, 0); chk("R1 rx_en", rx_en_o, 0);
   endtask

   task automatic t_hdr();
      logic [31:0] v;
      wr(1, 32'h1);                 // no abort
      @(negedge clk); hdr_sgl_err_i = 1; @(negedge clk); hdr_sgl_err_i = 0;
      rd(0, v); chk("R2 single-bit no flag", v, 0);
      p_hdr(); rd(0, v); chk("R2 header flag", v, 32'h1000);
      p_en(); rd(0, v); chk("R6 host enable clears", v, 0);
   endtask

   task automatic t_frames();
      logic [31:0] v;
      p_end(1); idle(3); rd(0, v); chk("R3 no flag before timestamp", v, 0);
      p_ts(0); rd(0, v); chk("R3 good frame", v, 32'h6000);
      p_en();
      p_end(0); idle(2); p_ts(1); rd(0, v); chk("R3 bad frame ts error", v, 32'hA000);
      p_en();
      p_ts(0); rd(0, v); chk("R4 timestamp alone", v, 0);
      p_end(1); p_en(); p_ts(0); rd(0, v); chk("R6 pending discarded", v, 0);
      // frame end and timestamp in the same cycle
      @(negedge clk); frm_end_i = 1; crc_ok_i = 1; ts_done_i = 1;
      @(negedge clk); frm_end_i = 0; crc_ok_i = 0; ts_done_i = 0;
      rd(0, v); chk("R3 same-cycle release", v, 32'h6000);
      p_en();
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      p_end(1); p_ts(0); p_end(0); p_ts(0); p_hdr();
      rd(0, v); chk("R5 all set", v, 32'hF000);
      wr(0, 32'h4000); rd(0, v); chk("R5 clear bit 14", v, 32'hB000);
      wr(0, 32'h0000); rd(0, v); chk("R5 zero write no effect", v, 32'hB000);
      wr(0, 32'hB000); rd(0, v); chk("R5 clear rest", v, 0);
      @(negedge clk); hdr_dbl_err_i = 1; wr_en_i = 1; wr_addr_i = 0; wr_data_i = 32'h1000;
      @(negedge clk); hdr_dbl_err_i = 0; wr_en_i = 0;
      rd(0, v); chk("R5 set wins", v, 32'h1000);
      p_en();
   endtask

   task automatic t_abort();
      logic [31:0] v;
      wr(1, 0);
      @(negedge clk); hdr_dbl_err_i = 1; @(negedge clk); hdr_dbl_err_i = 0;
      chk("R7 abort pulse", rx_abort_o, 1); chk("R7 no reen now", rx_en_o, 0);
      @(negedge clk); chk("R7 abort one cycle", rx_abort_o, 0); chk("R7 no reen when off", rx_en_o, 0);
      rd(0, v); chk("R7 flag kept without reen", v, 32'h1000);
      p_en();
      wr(1, 32'h3);
      p_hdr(); chk("R7 disabled abort", rx_abort_o, 0);
      @(negedge clk); chk("R7 no reen without abort", rx_en_o, 0);
      rd(0, v); chk("R7 flag stays", v, 32'h1000);
      p_en();
      wr(1, 32'h2);
      p_hdr(); chk("R7 abort with reen", rx_abort_o, 1);
      rd(0, v); chk("R7 flag before reen", v, 32'h1000);
      @(negedge clk); chk("R7 reen pulse", rx_en_o, 1);
      @(negedge clk); chk("R7 reen one cycle", rx_en_o, 0);
      rd(0, v); chk("R6 auto reen clears", v, 0);
      wr(1, 0);
   endtask

   task automatic t_counters();
      logic [31:0] v;
      wr(1, 32'h4);
      p_hdr(); p_hdr(); p_hdr();
      rd(3, v); chk("R8 header count", v, 3);
      p_end(0); p_ts(0); p_end(1); p_ts(0); p_end(0); p_ts(1);
      rd(4, v); chk("R8 crc error count", v, 2);
      wr(1, 32'h4); rd(3, v); chk("R9 no clear when already on", v, 3);
      wr(1, 0); p_hdr(); p_end(0); p_ts(0);
      rd(3, v); chk("R8 gated header", v, 3);
      rd(4, v); chk("R8 gated crc", v, 2);
      wr(1, 32'h4);
      rd(3, v); chk("R9 header cleared", v, 0);
      rd(4, v); chk("R9 crc cleared", v, 0);
      wr(1, 32'h5);
      @(negedge clk); hdr_dbl_err_i = 1; idle(4100); hdr_dbl_err_i = 0; @(negedge clk);
      rd(3, v); chk("R8 saturates", v, 4095);
      wr(1, 0); p_en();
   endtask

   task automatic t_irq();
      wr(1, 32'h1); wr(2, 32'h1000);
      chk("R10 no flag no irq", irq_o, 0);
      p_hdr(); chk("R10 irq on masked flag", irq_o, 1);
      wr(2, 32'h2000); chk("R10 mask off irq low", irq_o, 0);
      p_end(1); p_ts(0); chk("R10 ready raises irq", irq_o, 1);
      p_en(); chk("R10 irq drops on clear", irq_o, 0);
   endtask

   initial begin
      idle(2);
      t_reset();
      rst_n = 1;
      idle(2);
      t_reset();
      t_hdr();
      t_frames();
      t_w1c();
      t_abort();
      t_counters();
      t_irq();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule